// File: doc/BRIEF.md
# Register Bank with Set, Clear and Toggle Aliases

This block is a bank of 32-bit control and status registers for a peripheral. A simple word-addressed bus with separate read and write strobes reaches it. Every writable register except the status register has three extra addresses. A write to one of these sets, clears or toggles chosen bits of the register in a single bus write, so software needs no read-modify-write sequence. A read of any alias address returns the register it belongs to.

The control register holds a soft-reset bit, bit 31. When software asserts this bit, the power, transmit, receive and control registers return to their power-on values. Every other register keeps its contents. A hardware reset sets every register to its default value. The bank occupies a 4 KiB window, and only aligned 32-bit accesses are supported.

Top module: `regbank_sct`

## Requirements
- R1: The register number is byte offset bits [11:4], and bits [3:2] select the access type: 0 is the register itself, 1 is set, 2 is clear and 3 is toggle. Address bits [1:0] are ignored. The registers are power at 0x00, transmit at 0x10, receive at 0x20, control at 0x30, status at 0x40, debug at 0x50, debug0-status at 0x60, debug1 at 0x70 and version at 0x80.
- R2: A write to the set alias ORs wdata into the register. A write to the clear alias clears the bits that are 1 in wdata. A write to the toggle alias XORs wdata into the register.
- R3: A read of a set, clear or toggle alias of a register returns the current value of that register.
- R4: Writes are ignored at these addresses: the status aliases (0x44 to 0x4C), debug0-status, version, and every offset at or above 0x90. The status register itself takes direct writes. A read of the status aliases, or of any offset at or above 0x90, returns zero.
- R5: After hardware reset the registers hold these values: power 0x001E1C00, transmit 0x10060607, receive 0, control 0xC0200000, status 0, debug 0x7F180000, debug0-status 0, debug1 0x00001000 and version 0x04020000. rdata is 0.
- R6: A soft reset returns power, transmit, receive and control to their R5 values. Status, debug, debug0-status, debug1 and version keep their contents.
- R7: A soft reset starts on three kinds of control write, and in each case the soft-reset values replace the written result. The first is a direct write with wdata[31] = 1. The second is a set write with wdata[31] = 1. The third is a toggle write with wdata[31] = 1, but only when bit 31 of control is 1 after the toggle. A clear write never starts a soft reset.
- R8: rdata is loaded on the clock edge that samples rd_en and holds its value while rd_en is low. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The assertions run on every cycle. They check that the set alias ORs data into the power register and that a toggle-alias read returns the debug register. They check that a soft reset leaves status, debug and debug1 unchanged, that a clear write or a toggle that takes bit 31 to zero never starts a soft reset, and that rdata holds while no read is requested. Other behaviour depends on state built over several writes, so only the bench's scenarios can show it. This covers the full reset map, the ignored writes to read-only and unmapped addresses, a misaligned address reaching the same register, and the three soft-reset triggers followed by reads of the registers that were and were not restored.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   localparam int NSLOT    = 9;
   localparam int CTL_SLOT = 3;

   typedef enum logic [1:0] {
      OP_BASE = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_TOG  = 2'd3
   } alias_op_e;

   function automatic logic [31:0] slot_rst(input int s);
      case (s)
         0:       return 32'h001E_1C00;
         1:       return 32'h1006_0607;
         3:       return 32'hC020_0000;
         5:       return 32'h7F18_0000;
         7:       return 32'h0000_1000;
         8:       return 32'h0402_0000;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic bit slot_writable(input int s);
      return (s != 6) && (s != 8);
   endfunction

   function automatic bit slot_aliased(input int s);
      return slot_writable(s) && (s != 4);
   endfunction

   function automatic bit slot_soft(input int s);
      return s <= CTL_SLOT;
   endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
   import regbank_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NSLOT-1:0]  hit,
   output alias_op_e         op
);
   localparam int SLOT_W = ADDR_W - 4;

   logic [SLOT_W-1:0] slot;
   logic [1:0]        unused_lsb;

   assign slot       = addr[ADDR_W-1:4];
   assign op         = alias_op_e'(addr[3:2]);
   assign unused_lsb = addr[1:0];

   for (genvar s = 0; s < NSLOT; s++) begin : g_hit
      if (slot_aliased(s)) begin : g_al
         assign hit[s] = (slot == SLOT_W'(s));
      end else begin : g_plain
         assign hit[s] = (slot == SLOT_W'(s)) && (op == OP_BASE);
      end
   end
endmodule

// File: rtl/regbank_srst.sv
module regbank_srst
   import regbank_pkg::*;
(
   input  logic      we_ctl,
   input  alias_op_e op,
   input  logic      wr_bit,
   input  logic      cur_bit,
   output logic      srst
);
   always_comb begin
      srst = 1'b0;
      if (we_ctl) begin
         case (op)
            OP_BASE, OP_SET: srst = wr_bit;
            OP_TOG:          srst = wr_bit & ~cur_bit;
            default:         srst = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
   import regbank_pkg::*;
#(
   parameter int           W    = 32,
   parameter logic [W-1:0] RST  = '0,
   parameter bit           SOFT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  alias_op_e    op,
   input  logic [W-1:0] wdata,
   input  logic         srst,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;
   logic         soft_hit;

   always_comb begin
      case (op)
         OP_SET:  nxt = q | wdata;
         OP_CLR:  nxt = q & ~wdata;
         OP_TOG:  nxt = q ^ wdata;
         default: nxt = wdata;
      endcase
   end

   if (SOFT) begin : g_soft
      assign soft_hit = srst;
   end else begin : g_hard
      logic unused_srst;
      assign unused_srst = srst;
      assign soft_hit    = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RST;
      else if (soft_hit) q <= RST;
      else if (we)       q <= nxt;
   end
endmodule

// File: rtl/regbank_sct.sv
module regbank_sct
   import regbank_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int SRST_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   if (DATA_W != 32) begin : g_bad_w
      $error("regbank_sct: DATA_W must be 32");
   end
   if (ADDR_W < 8) begin : g_bad_a
      $error("regbank_sct: ADDR_W too small for the register map");
   end
   if (SRST_BIT >= DATA_W) begin : g_bad_b
      $error("regbank_sct: SRST_BIT outside the data word");
   end

   logic [NSLOT-1:0]  hit;
   alias_op_e         op;
   logic              srst;
   logic [DATA_W-1:0] regs_q [NSLOT];
   logic [DATA_W-1:0] rd_mux;

   regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .hit  (hit),
      .op   (op)
   );

   regbank_srst u_srst (
      .we_ctl  (wr_en && hit[CTL_SLOT]),
      .op      (op),
      .wr_bit  (wdata[SRST_BIT]),
      .cur_bit (regs_q[CTL_SLOT][SRST_BIT]),
      .srst    (srst)
   );

   for (genvar s = 0; s < NSLOT; s++) begin : g_reg
      if (slot_writable(s)) begin : g_rw
         regbank_cell #(
            .W    (DATA_W),
            .RST  (DATA_W'(slot_rst(s))),
            .SOFT (slot_soft(s))
         ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && hit[s]),
            .op    (op),
            .wdata (wdata),
            .srst  (srst),
            .q     (regs_q[s])
         );
      end else begin : g_ro
         assign regs_q[s] = DATA_W'(slot_rst(s));
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (hit[s]) rd_mux = rd_mux | regs_q[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end
endmodule

// File: rtl/regbank_sct_chk.sv
module regbank_sct_chk #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int SRST_BIT = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] pwr_q,
   input logic [DATA_W-1:0] ctl_q,
   input logic [DATA_W-1:0] sts_q,
   input logic [DATA_W-1:0] dbg_q,
   input logic [DATA_W-1:0] dbg1_q,
   input logic              srst
);
   localparam int IW = ADDR_W - 2;
   localparam logic [IW-1:0] PWR_SET = IW'(1);
   localparam logic [IW-1:0] CTL_CLR = IW'(14);
   localparam logic [IW-1:0] CTL_TOG = IW'(15);
   localparam logic [IW-1:0] DBG_TOG = IW'(23);

   logic [IW-1:0] widx;
   logic [1:0]    unused_lo;
   assign widx      = addr[ADDR_W-1:2];
   assign unused_lo = addr[1:0];

   AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == PWR_SET) |=> pwr_q == ($past(pwr_q) | $past(wdata))); // R2

   AST_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && widx == DBG_TOG) |=> rdata == $past(dbg_q)); // R3

   AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (pwr_q == DATA_W'(32'h001E_1C00)) && (ctl_q == DATA_W'(32'hC020_0000))); // R6

   AST_SRST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (sts_q == $past(sts_q)) && (dbg_q == $past(dbg_q)) && (dbg1_q == $past(dbg1_q))); // R6

   AST_CLR_NO_SRST: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == CTL_CLR) |-> !srst); // R7

   AST_TOG_LOW_NO_SRST: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == CTL_TOG && wdata[SRST_BIT] && ctl_q[SRST_BIT]) |-> !srst); // R7

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R8
endmodule

bind regbank_sct regbank_sct_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .SRST_BIT (SRST_BIT)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .rd_en  (rd_en),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .pwr_q  (regs_q[0]),
   .ctl_q  (regs_q[3]),
   .sts_q  (regs_q[4]),
   .dbg_q  (regs_q[5]),
   .dbg1_q (regs_q[7]),
   .srst   (srst)
);

// File: tb/sim_regbank_sct.sv
`timescale 1ns/1ps
module sim_regbank_sct;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] mdl [9];
   logic [31:0] exp_rd = '0;

   always #2 clk = ~clk;

   regbank_sct u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   function automatic logic [31:0] dflt(input int s);
      logic [31:0] v [9] = '{32'h001E1C00, 32'h10060607, 32'h0, 32'hC0200000,
                             32'h0, 32'h7F180000, 32'h0, 32'h00001000, 32'h04020000};
      return v[s];
   endfunction

   function automatic bit can_write(input int s, input int op);
      if (s > 8 || s == 6 || s == 8) return 0;
      if (s == 4 && op != 0) return 0;
      return 1;
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      int s  = int'(a[11:4]);
      int op = int'(a[3:2]);
      if (s > 8) return 32'h0;
      if (op != 0 && (s == 4 || s == 6 || s == 8)) return 32'h0;
      return mdl[s];
   endfunction

   task automatic m_write(input logic [11:0] a, input logic [31:0] d);
      int s  = int'(a[11:4]);
      int op = int'(a[3:2]);
      logic [31:0] nv;
      bit fire;
      if (!can_write(s, op)) return;
      case (op)
         1:       nv = mdl[s] | d;
         2:       nv = mdl[s] & ~d;
         3:       nv = mdl[s] ^ d;
         default: nv = d;
      endcase
      mdl[s] = nv;
      fire = (s == 3) && d[31] && (op == 0 || op == 1 || (op == 3 && nv[31]));
      if (fire) for (int k = 0; k < 4; k++) mdl[k] = dflt(k);
   endtask

   task automatic compare(input string req);
      n_cmp++;
      if (rdata !== exp_rd) begin
         n_bad++;
         $display("FAIL %s: rdata actual %h expected %h", req, rdata, exp_rd);
      end
   endtask

   task automatic cyc(input bit w, input bit r, input logic [11:0] a,
                      input logic [31:0] d, input string req);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d;
      if (r) exp_rd = m_read(a);
      if (w) m_write(a, d);
      @(posedge clk);
      #1;
      compare(req);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input string req);
      cyc(1'b0, 1'b1, a, 32'h0, req);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
      cyc(1'b1, 1'b0, a, d, req);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 50000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      for (int k = 0; k < 9; k++) mdl[k] = dflt(k);
      repeat (3) @(posedge clk);
      #1;
      compare("R5");
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < 9; k++) rd(12'(k * 16), "R5");
      rd(12'h090, "R4");
      rd(12'hFFC, "R4");
      rd(12'h044, "R4");
      rd(12'h04C, "R4");

      wr(12'h000, 32'hDEAD_BEEF, "R1");
      rd(12'h000, "R1");
      wr(12'h013, 32'h1234_5678, "R1");
      rd(12'h010, "R1");
      rd(12'h022, "R1");

      wr(12'h024, 32'h0000_F0F0, "R2");
      rd(12'h020, "R2");
      wr(12'h028, 32'h0000_3030, "R2");
      rd(12'h024, "R3");
      wr(12'h02C, 32'hFFFF_0000, "R2");
      rd(12'h02C, "R3");
      wr(12'h054, 32'h0000_00FF, "R2");
      wr(12'h058, 32'h7F00_0000, "R2");
      wr(12'h05C, 32'h0000_0F0F, "R2");
      rd(12'h058, "R3");
      wr(12'h074, 32'h0000_0003, "R2");
      wr(12'h07C, 32'h0000_1001, "R2");
      rd(12'h074, "R3");

      wr(12'h040, 32'h0000_00A5, "R4");
      wr(12'h044, 32'hFFFF_FFFF, "R4");
      wr(12'h048, 32'hFFFF_FFFF, "R4");
      rd(12'h040, "R4");
      wr(12'h060, 32'hFFFF_FFFF, "R4");
      wr(12'h080, 32'h0000_0000, "R4");
      wr(12'h084, 32'hFFFF_FFFF, "R4");
      wr(12'h0A0, 32'hFFFF_FFFF, "R4");
      rd(12'h060, "R4");
      rd(12'h080, "R4");
      rd(12'h0A0, "R4");

      wr(12'h030, 32'h8000_0001, "R7");
      for (int k = 0; k < 9; k++) rd(12'(k * 16), "R6");

      wr(12'h000, 32'h0000_0055, "R7");
      wr(12'h038, 32'h8000_0000, "R7");
      rd(12'h000, "R7");
      rd(12'h030, "R7");
      wr(12'h03C, 32'h8000_0000, "R7");
      rd(12'h000, "R7");
      rd(12'h030, "R7");

      wr(12'h010, 32'h0000_0077, "R7");
      wr(12'h03C, 32'h8000_0000, "R7");
      rd(12'h010, "R7");
      rd(12'h030, "R7");

      wr(12'h020, 32'h0000_0099, "R7");
      wr(12'h034, 32'h8000_0004, "R7");
      rd(12'h020, "R7");
      rd(12'h030, "R6");
      rd(12'h050, "R6");
      rd(12'h040, "R6");

      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b1; addr = 12'h000; wdata = 32'h0F0F_0F0F;
      exp_rd = m_read(12'h000);
      m_write(12'h000, 32'h0F0F_0F0F);
      @(posedge clk);
      #1;
      compare("R8");
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk);
         #1;
         compare("R8");
      end
      rd(12'h000, "R8");

      summary();
   end
endmodule